// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block decides, cycle by cycle, when the gate of a secondary-side synchronous rectifier switch should be driven. It receives two comparator results that have already been digitised and synchronised: one says the drain has dropped below the negative turn-on level, which means the body diode is conducting. The other says the drain has risen above the turn-off level. It also receives a trigger/disable line from the primary side and two blanking lengths counted in clock cycles. It produces a gate request and a flag that reports the low-power state.

After each turn-on the block holds the gate high for a minimum on window. After each turn-off it holds the gate low for a minimum off window. Each window has a hard floor, so a zero setting still gives a window of useful length. The trigger line turns the gate off early in continuous-conduction operation. It is masked from the end of the off window until the end of the next on window. A trigger that stays high long enough puts the block to sleep. On wake-up the block waits for a complete new switching cycle before it drives the gate again.

Top module: `sr_gate_ctrl`

## Requirements
- R1: After reset (asynchronous, active low) the gate request and the sleep flag are low. The first turn-on is allowed only after the turn-off flag has been seen high while the trigger was low.
- R2: When armed and idle, a high turn-on flag raises the gate on the next clock edge.
- R3: Once raised, the gate stays high for the whole minimum on window, whatever the turn-off flag does during that window.
- R4: After the on window, the gate stays high while the turn-off flag is low. It drops at the edge that samples the flag high. If the flag is already high on the last cycle of the window, the pulse lasts exactly the window.
- R5: Every turn-off starts a minimum off window. During that window the turn-on flag is ignored. If the turn-on flag is high on the window's last cycle, the gate rises at the next edge, so the low time is exactly the window.
- R6: The on window is max(ton_len_i, ON_FLOOR) cycles and the off window is max(toff_len_i, OFF_FLOOR) cycles. With lengths of zero they are ON_FLOOR and OFF_FLOOR.
- R7: A trigger sampled high after the on window has ended turns the gate off at the next edge. A trigger pulse one clock wide is enough.
- R8: The trigger is ignored while idle and during the on window. A pulse that begins while the trigger is already high ends after exactly the on window.
- R9: If the trigger is high on the last cycle of an off window, the block returns to the unarmed state. It turns on again only after the turn-off flag is seen high with the trigger low, so the cycle that follows is skipped.
- R10: A trigger held high for PRESCALE*SLEEP_TICKS consecutive cycles puts the block to sleep. The sleep flag is then high and the gate is held low. A low trigger restarts this count.
- R11: When the trigger falls during sleep, the sleep flag stays high for WAKE_CYCLES recovery cycles. The block then enters the unarmed state and does not turn on in a conduction interval that is already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_on_i | input | 1 | Drain below turn-on threshold (diode conducting) |
| above_off_i | input | 1 | Drain above turn-off threshold |
| trig_i | input | 1 | Trigger / disable line |
| ton_len_i | input | TMR_W | Requested minimum on time in cycles |
| toff_len_i | input | TMR_W | Requested minimum off time in cycles |
| gate_o | output | 1 | Gate-drive request |
| sleep_o | output | 1 | Low-power (sleep or recovery) status |

## Verification
The sequencing is driven with ringing patterns, in which the turn-off flag is high inside the on window and the turn-on flag is high inside the off window. These show that blanking works and separate a correct window length from an off-by-one. A one-cycle trigger after blanking, and a trigger that rises while idle and stays high, separate an accepted trigger from a masked one. A trigger held across the whole positive-drain interval tells the skipped-cycle rule apart from a plain re-arm. Zero lengths expose the floors. A long-high trigger followed by release during diode conduction checks the sleep threshold, the recovery delay, and the rule that no turn-on happens mid-conduction.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [2:0] {
    ST_ARM   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_ONB   = 3'd2,
    ST_ON    = 3'd3,
    ST_OFFB  = 3'd4,
    ST_SLEEP = 3'd5,
    ST_WAKE  = 3'd6
  } sr_state_e;

endpackage

// File: rtl/sr_blank_timer.sv
module sr_blank_timer #(
  parameter int TMR_W     = 16,
  parameter int ON_FLOOR  = 75,
  parameter int OFF_FLOOR = 150
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_on_i,
  input  logic             load_off_i,
  input  logic             run_i,
  input  logic [TMR_W-1:0] ton_len_i,
  input  logic [TMR_W-1:0] toff_len_i,
  output logic             last_o
);

  localparam logic [TMR_W-1:0] ON_MIN  = TMR_W'(ON_FLOOR);
  localparam logic [TMR_W-1:0] OFF_MIN = TMR_W'(OFF_FLOOR);
  localparam logic [TMR_W-1:0] ONE     = TMR_W'(1);

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic [TMR_W-1:0] eff_on, eff_off;
  logic             cnt_en;

  // clamp each requested length to its floor
  always_comb begin
    eff_on  = (ton_len_i  < ON_MIN)  ? ON_MIN  : ton_len_i;
    eff_off = (toff_len_i < OFF_MIN) ? OFF_MIN : toff_len_i;
  end

  assign last_o = (cnt_q == ONE);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_on_i) begin
      cnt_d  = eff_on;
      cnt_en = 1'b1;
    end else if (load_off_i) begin
      cnt_d  = eff_off;
      cnt_en = 1'b1;
    end else if (run_i && !last_o) begin
      cnt_d  = cnt_q - ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sr_sleep_timer.sv
module sr_sleep_timer #(
  parameter int PRESCALE    = 250,
  parameter int SLEEP_TICKS = 100000,
  parameter int WAKE_CYCLES = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic wake_run_i,
  output logic sleep_hit_o,
  output logic wake_done_o
);

  localparam int TICK_W = $clog2(SLEEP_TICKS + 1);
  localparam int WAKE_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLEEP_TICKS);
  localparam logic [WAKE_W-1:0] WAKE_LAST = WAKE_W'(WAKE_CYCLES - 1);

  logic tick;

  // prescaler: variant picked by PRESCALE
  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PRE_W = $clog2(PRESCALE);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_en;

      always_comb begin
        pre_en = trig_i || (pre_q != '0);
        if (!trig_i || (pre_q == PRE_LAST)) pre_d = '0;
        else                                pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (pre_en) pre_q <= pre_d;
      end

      assign tick = trig_i && (pre_q == PRE_LAST);
    end else begin : g_nopre
      assign tick = trig_i;
    end
  endgenerate

  logic [TICK_W-1:0] tick_q, tick_d;
  logic              tick_en;

  assign sleep_hit_o = (tick_q == TICK_LAST);

  always_comb begin
    tick_d  = tick_q;
    tick_en = 1'b0;
    if (!trig_i) begin
      tick_d  = '0;
      tick_en = (tick_q != '0);
    end else if (tick && !sleep_hit_o) begin
      tick_d  = tick_q + 1'b1;
      tick_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tick_q <= '0;
    else if (tick_en) tick_q <= tick_d;
  end

  // recovery delay after leaving sleep
  logic [WAKE_W-1:0] wake_q, wake_d;
  logic              wake_en;

  assign wake_done_o = wake_run_i && (wake_q == WAKE_LAST);

  always_comb begin
    wake_en = wake_run_i || (wake_q != '0);
    wake_d  = wake_run_i ? wake_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wake_q <= '0;
    else if (wake_en) wake_q <= wake_d;
  end

endmodule

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl
  import sr_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int ON_FLOOR    = 75,
  parameter int OFF_FLOOR   = 150,
  parameter int PRESCALE    = 250,
  parameter int SLEEP_TICKS = 100000,
  parameter int WAKE_CYCLES = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             below_on_i,
  input  logic             above_off_i,
  input  logic             trig_i,
  input  logic [TMR_W-1:0] ton_len_i,
  input  logic [TMR_W-1:0] toff_len_i,
  output logic             gate_o,
  output logic             sleep_o
);

  sr_state_e state_q, state_d;
  logic      tmr_last, sleep_hit, wake_done;
  logic      load_on, load_off, tmr_run;

  sr_blank_timer #(
    .TMR_W    (TMR_W),
    .ON_FLOOR (ON_FLOOR),
    .OFF_FLOOR(OFF_FLOOR)
  ) u_blank (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_on_i (load_on),
    .load_off_i(load_off),
    .run_i     (tmr_run),
    .ton_len_i (ton_len_i),
    .toff_len_i(toff_len_i),
    .last_o    (tmr_last)
  );

  sr_sleep_timer #(
    .PRESCALE   (PRESCALE),
    .SLEEP_TICKS(SLEEP_TICKS),
    .WAKE_CYCLES(WAKE_CYCLES)
  ) u_sleep (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig_i),
    .wake_run_i (state_q == ST_WAKE),
    .sleep_hit_o(sleep_hit),
    .wake_done_o(wake_done)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ARM:   if (above_off_i && !trig_i) state_d = ST_IDLE;
      ST_IDLE:  if (below_on_i) state_d = ST_ONB;
      ST_ONB:   if (tmr_last) state_d = (above_off_i || trig_i) ? ST_OFFB : ST_ON;
      ST_ON:    if (above_off_i || trig_i) state_d = ST_OFFB;
      ST_OFFB: begin
        if (tmr_last) begin
          if (trig_i)          state_d = ST_ARM;
          else if (below_on_i) state_d = ST_ONB;
          else                 state_d = ST_IDLE;
        end
      end
      ST_SLEEP: if (!trig_i) state_d = ST_WAKE;
      ST_WAKE: begin
        if (trig_i)         state_d = ST_SLEEP;
        else if (wake_done) state_d = ST_ARM;
      end
      default:  state_d = ST_ARM;
    endcase
    if (sleep_hit && (state_q != ST_SLEEP) && (state_q != ST_WAKE))
      state_d = ST_SLEEP;
  end

  assign load_on  = (state_d == ST_ONB)  && (state_q != ST_ONB);
  assign load_off = (state_d == ST_OFFB) && (state_q != ST_OFFB);
  assign tmr_run  = (state_q == ST_ONB) || (state_q == ST_OFFB);

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ARM;
    else        state_q <= state_d;
  end

  assign gate_o  = (state_q == ST_ONB)   || (state_q == ST_ON);
  assign sleep_o = (state_q == ST_SLEEP) || (state_q == ST_WAKE);

endmodule

// File: rtl/sr_gate_ctrl_chk.sv
module sr_gate_ctrl_chk
  import sr_pkg::*;
#(
  parameter int TMR_W    = 16,
  parameter int ON_FLOOR = 75
) (
  input logic      clk,
  input logic      rst_n,
  input logic      below_on_i,
  input logic      above_off_i,
  input logic      trig_i,
  input logic      gate_o,
  input logic      sleep_o,
  input sr_state_e state_q
);

  localparam logic [TMR_W:0] ON_MIN = (TMR_W+1)'(ON_FLOOR);

  logic [TMR_W:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (!gate_o)    run_q <= '0;
    else if (run_q != '1) run_q <= run_q + 1'b1;
  end

  a_r2_rise_needs_sense: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(below_on_i));

  a_r3_held_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |=> gate_o);

  a_r4_off_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON && above_off_i) |=> !gate_o);

  a_r5_low_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |=> !gate_o);

  a_r6_on_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_o) && !sleep_o) |-> (run_q >= ON_MIN));

  a_r7_trig_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON && trig_i) |=> !gate_o);

  a_r10_sleep_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !gate_o);

  a_r11_wake_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_o) |-> (!gate_o && state_q == ST_ARM));

endmodule

bind sr_gate_ctrl sr_gate_ctrl_chk #(
  .TMR_W   (TMR_W),
  .ON_FLOOR(ON_FLOOR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .below_on_i (below_on_i),
  .above_off_i(above_off_i),
  .trig_i     (trig_i),
  .gate_o     (gate_o),
  .sleep_o    (sleep_o),
  .state_q    (state_q)
);

// File: tb/sim_sr_gate_ctrl.sv
module sim_sr_gate_ctrl;

  localparam int TMR_W = 8;
  localparam int NV    = 20;

  logic             clk;
  logic             rst_n;
  logic             below_on_i, above_off_i, trig_i;
  logic [TMR_W-1:0] ton_len_i, toff_len_i;
  logic             gate_o, sleep_o;

  int checks;
  int fails;

  sr_gate_ctrl #(
    .TMR_W      (TMR_W),
    .ON_FLOOR   (4),
    .OFF_FLOOR  (6),
    .PRESCALE   (4),
    .SLEEP_TICKS(25),
    .WAKE_CYCLES(5)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .below_on_i (below_on_i),
    .above_off_i(above_off_i),
    .trig_i     (trig_i),
    .ton_len_i  (ton_len_i),
    .toff_len_i (toff_len_i),
    .gate_o     (gate_o),
    .sleep_o    (sleep_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {req[4], below, above, trig, edges[8], exp_gate, exp_sleep}; ton=10 toff=8
  localparam logic [16:0] VEC [NV] = '{
    {4'd1, 1'b1, 1'b0, 1'b0, 8'd3,  1'b0, 1'b0},  // R1 not armed yet
    {4'd1, 1'b0, 1'b1, 1'b0, 8'd1,  1'b0, 1'b0},  // R1 arm
    {4'd2, 1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 1'b0},  // R2 turn on
    {4'd3, 1'b0, 1'b1, 1'b0, 8'd8,  1'b1, 1'b0},  // R3 ringing masked
    {4'd3, 1'b0, 1'b1, 1'b0, 8'd1,  1'b1, 1'b0},  // R3 last window cycle
    {4'd4, 1'b0, 1'b1, 1'b0, 8'd1,  1'b0, 1'b0},  // R4 off at window end
    {4'd5, 1'b1, 1'b0, 1'b0, 8'd7,  1'b0, 1'b0},  // R5 turn-on masked
    {4'd5, 1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 1'b0},  // R5 on at off-window end
    {4'd4, 1'b0, 1'b0, 1'b0, 8'd10, 1'b1, 1'b0},  // R4 stays on
    {4'd4, 1'b0, 1'b0, 1'b0, 8'd5,  1'b1, 1'b0},  // R4 still on
    {4'd7, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 1'b0},  // R7 one-cycle trigger
    {4'd5, 1'b0, 1'b1, 1'b0, 8'd8,  1'b0, 1'b0},  // R5 off window to idle
    {4'd8, 1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 1'b0},  // R8 trigger ignored in idle
    {4'd8, 1'b0, 1'b0, 1'b1, 8'd9,  1'b1, 1'b0},  // R8 masked in on window
    {4'd8, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 1'b0},  // R8 pulse ends at window
    {4'd9, 1'b0, 1'b1, 1'b1, 8'd8,  1'b0, 1'b0},  // R9 trig high at window end
    {4'd9, 1'b1, 1'b0, 1'b1, 8'd2,  1'b0, 1'b0},  // R9 conduction skipped
    {4'd9, 1'b1, 1'b0, 1'b0, 8'd3,  1'b0, 1'b0},  // R9 still unarmed
    {4'd9, 1'b0, 1'b1, 1'b0, 8'd1,  1'b0, 1'b0},  // R9 re-arm
    {4'd9, 1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 1'b0}   // R9 next cycle drives
  };

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    checks = 0;
    fails  = 0;
    rst_n = 1'b0;
    below_on_i = 1'b0; above_off_i = 1'b0; trig_i = 1'b0;
    ton_len_i = 8'd10; toff_len_i = 8'd8;
    repeat (3) @(negedge clk);
    check_bit("R1 reset gate", gate_o, 1'b0);
    check_bit("R1 reset sleep", sleep_o, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      below_on_i  = VEC[i][12];
      above_off_i = VEC[i][11];
      trig_i      = VEC[i][10];
      edges(int'(VEC[i][9:2]));
      check_bit($sformatf("R%0d row %0d gate", VEC[i][16:13], i), gate_o, VEC[i][1]);
      check_bit($sformatf("R%0d row %0d sleep", VEC[i][16:13], i), sleep_o, VEC[i][0]);
    end

    // R1: asynchronous reset while driving
    rst_n = 1'b0;
    below_on_i = 1'b0; above_off_i = 1'b0; trig_i = 1'b0;
    #1;
    check_bit("R1 async reset gate", gate_o, 1'b0);
    check_bit("R1 async reset sleep", sleep_o, 1'b0);

    // R6: floors with zero lengths
    ton_len_i = '0; toff_len_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    above_off_i = 1'b1;
    edges(1);
    above_off_i = 1'b0; below_on_i = 1'b1;
    edges(1);
    check_bit("R6 turn on", gate_o, 1'b1);
    below_on_i = 1'b0; above_off_i = 1'b1;
    n = 0;
    while (gate_o && n < 100) begin n++; edges(1); end
    check_int("R6 on floor cycles", n, 4);
    below_on_i = 1'b1; above_off_i = 1'b0;
    n = 0;
    while (!gate_o && n < 100) begin n++; edges(1); end
    check_int("R6 off floor cycles", n, 6);

    // R10: long-high trigger enters sleep after 100 cycles
    below_on_i = 1'b0; above_off_i = 1'b0; trig_i = 1'b1;
    edges(97);
    check_bit("R10 not yet asleep", sleep_o, 1'b0);
    below_on_i = 1'b1;
    edges(6);
    check_bit("R10 asleep", sleep_o, 1'b1);
    check_bit("R10 gate held low", gate_o, 1'b0);

    // R11: wake during diode conduction
    trig_i = 1'b0;
    edges(4);
    check_bit("R11 recovering flag", sleep_o, 1'b1);
    check_bit("R11 recovering gate", gate_o, 1'b0);
    edges(4);
    check_bit("R11 awake", sleep_o, 1'b0);
    check_bit("R11 no mid-conduction turn-on", gate_o, 1'b0);
    below_on_i = 1'b0; above_off_i = 1'b1;
    edges(1);
    above_off_i = 1'b0; below_on_i = 1'b1;
    edges(1);
    check_bit("R11 fresh cycle drives", gate_o, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule